// File: doc/BRIEF.md
# Directional 7-Tap Normalising Smoother

This block performs the last, direction-dependent stage of a steerable Gaussian smoother. The image it receives has already been smoothed by an isotropic kernel. The block then applies a fixed seven-tap one-dimensional Gaussian along one axis of the image. It gathers seven pixels along the chosen axis, multiplies each one by its fixed weight and adds the products. It then divides the total by the exact weight sum, so the result is again an 8-bit pixel.

Pixels arrive as a raster stream, one 8-bit sample per accepted cycle. The first pixel of every frame is flagged. A direction select is captured on that first pixel and holds for the whole frame. When the select is 0, the window runs along the row. When it is 1, the window runs down the column, and six internal line delays, each as long as the image width, supply the pixels from earlier rows. Each result leaves exactly two cycles after the pixel that completes its window. The result stream carries a valid flag, which stays low while a window is still filling.

Top module: `smoothTop`

## Requirements
- R1: The output pixel is (S + 167) divided by 334 and truncated. S is the sum over the window of pixel times weight, with weights 8, 33, 76, 100, 76, 33, 8. All inputs of 255 therefore give 255.
- R2: A window holding 52, 42, 31, 48, 54, 37, 50 gives the output 44.
- R3: `outValid` rises exactly two clock cycles after the accepted pixel that completes a window, and never at any other time.
- R4: With direction 0 (horizontal), the window is the current pixel and the six pixels before it in the same row. A pixel at column index 6 or higher produces a result. Columns 0 to 5 produce none.
- R5: With direction 1 (vertical), the window is the current pixel and the pixels at the same column in the six previous rows. A pixel in row index 6 or higher produces a result. Rows 0 to 5 produce none.
- R6: `modeSel` is sampled only together with an accepted pixel that has `frameStart` high. Changes to `modeSel` during the rest of the frame have no effect on the results.
- R7: Reset clears `outValid`. Pixels accepted after reset and before the first `frameStart` produce no output. `frameStart` restarts row and column counting at row 0, column 0.
- R8: Cycles with `pixValid` low do not change the window, the counters or the line delays. Idle gaps therefore do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pixIn | input | 8 | Input pixel |
| pixValid | input | 1 | Input pixel is accepted this cycle |
| frameStart | input | 1 | Marks the first pixel of a frame (qualified by pixValid) |
| modeSel | input | 1 | Direction: 0 horizontal, 1 vertical; sampled at frame start |
| outPix | output | 8 | Normalised smoothed pixel |
| outValid | output | 1 | outPix holds a result |

## Verification
The assertions check three things on every cycle: the two-cycle link between an accepted pixel and a result, the absence of any result before the first frame start, and the absence of a result from the first pixel of a frame. The bench runs frames in both directions and checks the exact pixel values, the rounding near the edges of the quotient, and where the fill boundary falls at row 6 or column 6. Those checks need an independent arithmetic model, as do the proofs that idle gaps and `modeSel` toggles in the middle of a frame leave every result unchanged.

// File: rtl/smoothPkg.sv
package smoothPkg;
  localparam int PIX_W = 8;
  localparam int TAPS = 7;
  localparam int WEIGHT_W = 7;
  localparam int PROD_W = PIX_W + WEIGHT_W;
  localparam int SUM_W = PROD_W + 3;

  function automatic int tapWeight(input int idx);
    case (idx)
      0, 6: return 8;
      1, 5: return 33;
      2, 4: return 76;
      default: return 100;
    endcase
  endfunction

  function automatic int weightTotal();
    int acc;
    acc = 0;
    for (int i = 0; i < TAPS; i++) acc += tapWeight(i);
    return acc;
  endfunction

  localparam int WEIGHT_SUM = weightTotal();
  localparam int HALF_SUM = WEIGHT_SUM / 2;
  localparam int NORM_SHIFT = 25;
  localparam longint NORM_RECIP = ((64'd1 << NORM_SHIFT) + WEIGHT_SUM - 1) / WEIGHT_SUM;
  localparam int RECIP_W = 17;

  typedef struct packed {
    logic accept;
    logic vertical;
    logic windowOk;
  } ctrlStrobe_t;
endpackage

// File: rtl/lineDelay.sv
module lineDelay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      mem[0] <= din;
      for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
    end
  end

  assign dout = mem[DEPTH-1];
endmodule

// File: rtl/smoothCtrl.sv
module smoothCtrl
  import smoothPkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pixValid,
  input  logic        frameStart,
  input  logic        modeSel,
  output ctrlStrobe_t strobe
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int FILL = TAPS - 1;

  logic             started;
  logic             modeReg;
  logic [COL_W-1:0] colCnt;
  logic [2:0]       rowCnt;
  logic [COL_W-1:0] curCol;
  logic [2:0]       curRow;
  logic             curMode;
  logic             active;
  logic             colWrap;

  always_comb begin
    curCol  = frameStart ? '0 : colCnt;
    curRow  = frameStart ? '0 : rowCnt;
    curMode = frameStart ? modeSel : modeReg;
    active  = frameStart | started;
    colWrap = (curCol == COL_W'(IMG_W - 1));
    strobe.accept   = pixValid;
    strobe.vertical = curMode;
    strobe.windowOk = pixValid & active &
                      (curMode ? (curRow >= 3'(FILL)) : (curCol >= COL_W'(FILL)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      modeReg <= 1'b0;
      colCnt  <= '0;
      rowCnt  <= '0;
    end else if (pixValid && active) begin
      if (frameStart) begin
        started <= 1'b1;
        modeReg <= modeSel;
      end
      colCnt <= colWrap ? '0 : curCol + 1'b1;
      if (colWrap && curRow != 3'(FILL)) rowCnt <= curRow + 1'b1;
      else rowCnt <= curRow;
    end
  end
endmodule

// File: rtl/smoothPath.sv
module smoothPath
  import smoothPkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pixIn,
  input  ctrlStrobe_t      strobe,
  output logic [PIX_W-1:0] outPix,
  output logic             outValid
);
  localparam int LINES = TAPS - 1;
  localparam int MUL_W = SUM_W + RECIP_W;

  logic [PIX_W-1:0]  hTap    [LINES];
  logic [PIX_W-1:0]  lineOut [LINES];
  logic [PIX_W-1:0]  win     [TAPS];
  logic [PROD_W-1:0] prodReg [TAPS];
  logic              vld1;
  logic [SUM_W-1:0]  sumComb;
  logic [MUL_W-1:0]  scaled;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    if (g == 0) begin : gFirst
      lineDelay #(.WIDTH(PIX_W), .DEPTH(IMG_W)) uDelay (
        .clk(clk), .en(strobe.accept), .din(pixIn), .dout(lineOut[g]));
    end else begin : gNext
      lineDelay #(.WIDTH(PIX_W), .DEPTH(IMG_W)) uDelay (
        .clk(clk), .en(strobe.accept), .din(lineOut[g-1]), .dout(lineOut[g]));
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      hTap[0] <= pixIn;
      for (int i = 1; i < LINES; i++) hTap[i] <= hTap[i-1];
    end
  end

  always_comb begin
    win[0] = pixIn;
    for (int i = 1; i < TAPS; i++)
      win[i] = strobe.vertical ? lineOut[i-1] : hTap[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1 <= 1'b0;
      for (int i = 0; i < TAPS; i++) prodReg[i] <= '0;
    end else begin
      vld1 <= strobe.windowOk;
      if (strobe.accept)
        for (int i = 0; i < TAPS; i++)
          prodReg[i] <= PROD_W'(win[i]) * PROD_W'(tapWeight(i));
    end
  end

  always_comb begin
    sumComb = SUM_W'(HALF_SUM);
    for (int i = 0; i < TAPS; i++) sumComb = sumComb + SUM_W'(prodReg[i]);
    scaled = MUL_W'(sumComb) * MUL_W'(NORM_RECIP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= vld1;
      outPix   <= scaled[NORM_SHIFT +: PIX_W];
    end
  end
endmodule

// File: rtl/smoothTop.sv
module smoothTop
  import smoothPkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pixIn,
  input  logic       pixValid,
  input  logic       frameStart,
  input  logic       modeSel,
  output logic [7:0] outPix,
  output logic       outValid
);
  ctrlStrobe_t strobe;

  smoothCtrl #(.IMG_W(IMG_W)) uCtrl (
    .clk(clk), .rst(rst), .pixValid(pixValid), .frameStart(frameStart),
    .modeSel(modeSel), .strobe(strobe));

  smoothPath #(.IMG_W(IMG_W)) uPath (
    .clk(clk), .rst(rst), .pixIn(pixIn), .strobe(strobe),
    .outPix(outPix), .outValid(outValid));
endmodule

// File: rtl/smoothChk.sv
module smoothChk (
  input logic       clk,
  input logic       rst,
  input logic       pixValid,
  input logic       frameStart,
  input logic [7:0] outPix,
  input logic       outValid
);
  logic sawFrame;

  always_ff @(posedge clk) begin
    if (rst) sawFrame <= 1'b0;
    else if (pixValid && frameStart) sawFrame <= 1'b1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(pixValid, 2));

  assert_no_output_before_frame_R7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> sawFrame);

  assert_first_pixel_fills_R4: assert property (@(posedge clk) disable iff (rst)
    $past(pixValid && frameStart, 2) |-> !outValid);

  assert_result_known_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !$isunknown(outPix));
endmodule

bind smoothTop smoothChk u_chk (
  .clk(clk), .rst(rst), .pixValid(pixValid), .frameStart(frameStart),
  .outPix(outPix), .outValid(outValid));

// File: tb/smoothTop_tb.sv
`timescale 1ns/1ps
module smoothTop_tb;
  localparam int W = 8;
  localparam int H = 8;
  localparam int NEXP = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pixIn = '0;
  logic       pixValid = 1'b0;
  logic       frameStart = 1'b0;
  logic       modeSel = 1'b0;
  logic [7:0] outPix;
  logic       outValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic  expV [NEXP];
  int    expD [NEXP];
  string expT [NEXP];
  int    img  [H][W];
  int    exVals [7] = '{52, 42, 31, 48, 54, 37, 50};
  int    wts [7] = '{8, 33, 76, 100, 76, 33, 8};

  always #2.5 clk = ~clk;

  smoothTop #(.IMG_W(W)) u_dut (
    .clk(clk), .rst(rst), .pixIn(pixIn), .pixValid(pixValid),
    .frameStart(frameStart), .modeSel(modeSel),
    .outPix(outPix), .outValid(outValid));

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finishRun();
  end

  task automatic checkNow();
    checks++;
    if (outValid !== expV[cyc]) begin
      errors++;
      $display("FAIL %s/R3 cycle %0d outValid actual %b expected %b",
               expT[cyc], cyc, outValid, expV[cyc]);
    end
    if (expV[cyc]) begin
      checks++;
      if (outPix !== 8'(expD[cyc])) begin
        errors++;
        $display("FAIL %s cycle %0d outPix actual %0d expected %0d",
                 expT[cyc], cyc, outPix, expD[cyc]);
      end
    end
  endtask

  task automatic step(input logic v, input int p, input logic fs, input logic ms,
                      input logic ev, input int ed, input string tg);
    checkNow();
    pixValid   = v;
    pixIn      = 8'(p);
    frameStart = fs;
    modeSel    = ms;
    expV[cyc+2] = ev;
    expD[cyc+2] = ed;
    expT[cyc+2] = tg;
    cyc++;
    @(negedge clk);
  endtask

  // R1: rounded normalisation computed by plain integer division
  function automatic int expect7(input bit vert, input int r, input int c);
    int s;
    s = 0;
    for (int k = 0; k < 7; k++)
      s += wts[k] * (vert ? img[r-k][c] : img[r][c-k]);
    return (s + 167) / 334;
  endfunction

  function automatic int patPix(input int kind, input int seed, input int r, input int c);
    case (kind)
      1: return 255;
      2: return 0;
      3: return (r == 0 && c < 7) ? exVals[c] : ((r * 29 + c * 71) & 255);
      default: return (seed * 37 + r * 53 + c * 97 + r * c * 11) & 255;
    endcase
  endfunction

  // kind: 0 formula, 1 all 255, 2 all 0, 3 example row
  task automatic sendFrame(input int kind, input int seed, input bit vert,
                           input bit gaps, input bit toggle, input string tg);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        bit    ev;
        int    ed;
        string t;
        logic  ms;
        img[r][c] = patPix(kind, seed, r, c);
        ev = vert ? (r >= 6) : (c >= 6);
        ed = ev ? expect7(vert, r, c) : 0;
        t  = (kind == 3 && r == 0 && c == 6) ? "R2" : tg;
        ms = (r == 0 && c == 0) ? vert : (toggle ? ~vert : vert);
        step(1'b1, img[r][c], (r == 0 && c == 0), ms, ev, ed, t);
        if (gaps && ((r * W + c + seed) % 5 == 0))
          step(1'b0, 8'hA5, 1'b1, ~vert, 1'b0, 0, "R8");
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NEXP; i++) begin
      expV[i] = 1'b0;
      expD[i] = 0;
      expT[i] = "R7";
    end
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset outValid actual %b expected 0", outValid);
    end
    rst = 1'b0;
    // R7: pixels before any frame start yield nothing
    for (int i = 0; i < 12; i++) step(1'b1, i * 20, 1'b0, 1'b0, 1'b0, 0, "R7");
    sendFrame(3, 0, 1'b0, 1'b0, 1'b0, "R1");     // R2 example, horizontal
    sendFrame(0, 1, 1'b0, 1'b0, 1'b0, "R4");
    sendFrame(0, 2, 1'b1, 1'b0, 1'b0, "R5");
    sendFrame(0, 3, 1'b0, 1'b1, 1'b0, "R8");
    sendFrame(0, 4, 1'b1, 1'b1, 1'b0, "R8");
    sendFrame(0, 5, 1'b0, 1'b0, 1'b1, "R6");
    sendFrame(0, 6, 1'b1, 1'b0, 1'b1, "R6");
    sendFrame(1, 0, 1'b0, 1'b0, 1'b0, "R1");
    sendFrame(2, 0, 1'b1, 1'b0, 1'b0, "R1");
    sendFrame(1, 0, 1'b1, 1'b1, 1'b0, "R1");
    for (int s = 7; s < 13; s++) sendFrame(0, s, s[0], s[1], s[2], "R1");
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R3");
    finishRun();
  end
endmodule